// File: doc/BRIEF.md
# Page-Addressed Dual-Port Display Memory

This block holds the pixel image of a dot-matrix panel as an array of byte-wide cells. A cell is picked by a page number and a column number. Its eight bits are eight pixels stacked vertically: bit 0 is the top line of the page and bit 7 is the bottom line. A host side loads a page register and a column register with strobed commands. It then writes or reads data bytes, and the column moves on by one after every data access. A second, independent port lets the refresh logic fetch any cell at any time. Host traffic never stalls the panel, and the panel never stalls the host.

A geometry input selects between two layouts. In layout 0 the array is 132 columns wide, with sixteen full pages (0 to 15). In layout 1 it is 160 columns wide, with twelve full pages (0 to 11) and a half page (12) of four lines. In both layouts, page 16 is an icon row that keeps only a single line. Changing the layout sends the host address back to page 0, column 0.

Top module: `disp_page_ram`

## Requirements
- R1: With geoMode=0 the last column is 131. Pages 0 to 15 store and return all eight bits written.
- R2: With geoMode=1 the last column is 159. Pages 0 to 11 store all eight bits. Page 12 keeps bits 3:0 only, and bits 7:4 read as zero on both ports.
- R3: Page 16 is the icon page in both layouts. It keeps only bit 0, and bits 7:1 read as zero on both ports.
- R4: When hostSetPage is high, the value on hostData is loaded into the page register only if it is valid. Valid values are 0 to 15 (geoMode=0) or 0 to 12 (geoMode=1), plus 16 in both layouts. Any other value is ignored, and the register keeps its value.
- R5: When hostSetCol is high, the value on hostData is loaded into the column register only if it is no greater than the last column of the active layout. Otherwise it is ignored.
- R6: After each accepted host write or read, the column register increments by one. At the last column of the active layout it stays put, so further writes land on that column.
- R7: A host read returns the addressed byte on hostRdData one cycle after hostRd. The value holds until the next accepted read.
- R8: When dispRe is high, dispData carries the masked byte at (dispPage, dispCol) one cycle later. This happens regardless of host activity. Addresses beyond page 16 or column 159 return zero.
- R9: When a host write and a display read hit the same cell in the same cycle, the display port returns the data from before the write.
- R10: Only one host strobe acts per cycle, in this priority order: hostSetPage, then hostSetCol, then hostWr, then hostRd. This holds even when a set-page value is rejected.
- R11: In the first cycle after geoMode changes, the page and column registers go to 0. Any host strobe in that cycle is ignored.
- R12: While rstN is low, hostRdData and dispData are 0 and the host address is page 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| geoMode | input | 1 | Layout select: 0 = 132 columns, 1 = 160 columns |
| hostSetPage | input | 1 | Load page register from hostData |
| hostSetCol | input | 1 | Load column register from hostData |
| hostWr | input | 1 | Write hostData at the current address |
| hostRd | input | 1 | Read the byte at the current address |
| hostData | input | 8 | Command value or write data |
| hostRdData | output | 8 | Host read result |
| dispRe | input | 1 | Display-side read enable |
| dispPage | input | 5 | Display-side page |
| dispCol | input | 8 | Display-side column |
| dispData | output | 8 | Display-side read result |

## Verification
The host address registers are not visible at the ports, so a wrong page or column shows up only as data in the wrong place. That error appears when the cell is next fetched: on dispData one cycle after a display read of the intended cell, or on hostRdData after a later host read. Faults in the masking show up as nonzero upper bits on the icon row or the half page within one cycle of the read. A wrong collision order shows up as the new value on dispData in the cycle that should still carry the old one. The bench therefore reads written cells back through both ports, often straight after the write.

// File: rtl/disp_page_ram_pkg.sv
package disp_page_ram_pkg;

  typedef struct packed {
    logic       we;
    logic       re;
    logic [4:0] page;
    logic [7:0] col;
    logic [7:0] wdata;
  } memCmd_t;

  // Bits kept by a page in a given layout
  function automatic logic [7:0] lineMask(input logic [4:0] page, input logic mode,
                                          input logic [4:0] iconPage,
                                          input logic [4:0] partPage);
    if (page == iconPage)               return 8'h01;
    else if (mode && page == partPage)  return 8'h0F;
    else                                return 8'hFF;
  endfunction

endpackage

// File: rtl/dpr_ctrl.sv
module dpr_ctrl
  import disp_page_ram_pkg::*;
#(
  parameter int COLS_A      = 132,
  parameter int COLS_B      = 160,
  parameter int LAST_PAGE_A = 15,
  parameter int LAST_PAGE_B = 12,
  parameter int ICON_PAGE   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       geoMode,
  input  logic       hostSetPage,
  input  logic       hostSetCol,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostData,
  output memCmd_t    memCmd,
  output logic [4:0] curPage,
  output logic [7:0] curCol
);

  localparam logic [7:0] LAST_COL_A = 8'(COLS_A - 1);
  localparam logic [7:0] LAST_COL_B = 8'(COLS_B - 1);
  localparam logic [7:0] LAST_PG_A  = 8'(LAST_PAGE_A);
  localparam logic [7:0] LAST_PG_B  = 8'(LAST_PAGE_B);
  localparam logic [7:0] ICON_PG    = 8'(ICON_PAGE);

  logic       modeQ;
  logic       modeChg;
  logic [7:0] lastCol;
  logic       pageOk;
  logic       colOk;
  logic       dataAcc;

  always_comb begin
    modeChg = (geoMode != modeQ);
    lastCol = geoMode ? LAST_COL_B : LAST_COL_A;
    pageOk  = (hostData == ICON_PG) ||
              (hostData <= (geoMode ? LAST_PG_B : LAST_PG_A));
    colOk   = (hostData <= lastCol);
    dataAcc = !modeChg && !hostSetPage && !hostSetCol && (hostWr || hostRd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      curPage <= '0;
      curCol  <= '0;
    end else begin
      modeQ <= geoMode;
      if (modeChg) begin
        curPage <= '0;
        curCol  <= '0;
      end else if (hostSetPage) begin
        if (pageOk) curPage <= hostData[4:0];
      end else if (hostSetCol) begin
        if (colOk) curCol <= hostData;
      end else if (hostWr || hostRd) begin
        if (curCol < lastCol) curCol <= curCol + 8'd1;
      end
    end
  end

  always_comb begin
    memCmd.we    = dataAcc && hostWr;
    memCmd.re    = dataAcc && !hostWr && hostRd;
    memCmd.page  = curPage;
    memCmd.col   = curCol;
    memCmd.wdata = hostData;
  end

endmodule

// File: rtl/dpr_store.sv
module dpr_store
  import disp_page_ram_pkg::*;
#(
  parameter int MAX_COLS  = 160,
  parameter int ICON_PAGE = 16,
  parameter int PART_PAGE = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       geoMode,
  input  memCmd_t    memCmd,
  output logic [7:0] hostRdData,
  input  logic       dispRe,
  input  logic [4:0] dispPage,
  input  logic [7:0] dispCol,
  output logic [7:0] dispData
);

  localparam int         DEPTH  = (ICON_PAGE + 1) * MAX_COLS;
  localparam int         IDX_W  = $clog2(DEPTH);
  localparam logic [4:0] ICON_P = 5'(ICON_PAGE);
  localparam logic [4:0] PART_P = 5'(PART_PAGE);
  localparam logic [7:0] COL_LIM = 8'(MAX_COLS - 1);

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] hostIdx;
  logic [IDX_W-1:0] dispIdx;
  logic [7:0]       hostMask;
  logic [7:0]       dispMask;
  logic             dispInRange;

  always_comb begin
    hostIdx     = IDX_W'(int'(memCmd.page) * MAX_COLS + int'(memCmd.col));
    dispIdx     = IDX_W'(int'(dispPage) * MAX_COLS + int'(dispCol));
    hostMask    = lineMask(memCmd.page, geoMode, ICON_P, PART_P);
    dispMask    = lineMask(dispPage, geoMode, ICON_P, PART_P);
    dispInRange = (dispPage <= ICON_P) && (dispCol <= COL_LIM);
  end

  // Storage array: no reset, written only by the host side
  always_ff @(posedge clk) begin
    if (memCmd.we) mem[hostIdx] <= memCmd.wdata & hostMask;
  end

  // Read registers sample the array before this edge's write lands
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData <= '0;
      dispData   <= '0;
    end else begin
      if (memCmd.re) hostRdData <= mem[hostIdx] & hostMask;
      if (dispRe)    dispData   <= dispInRange ? (mem[dispIdx] & dispMask) : 8'h00;
    end
  end

endmodule

// File: rtl/disp_page_ram.sv
module disp_page_ram
  import disp_page_ram_pkg::*;
#(
  parameter int COLS_A      = 132,
  parameter int COLS_B      = 160,
  parameter int LAST_PAGE_A = 15,
  parameter int LAST_PAGE_B = 12,
  parameter int ICON_PAGE   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       geoMode,
  input  logic       hostSetPage,
  input  logic       hostSetCol,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostData,
  output logic [7:0] hostRdData,
  input  logic       dispRe,
  input  logic [4:0] dispPage,
  input  logic [7:0] dispCol,
  output logic [7:0] dispData
);

  localparam int MAX_COLS = (COLS_A > COLS_B) ? COLS_A : COLS_B;

  memCmd_t    memCmd;
  logic [4:0] curPage;
  logic [7:0] curCol;

  dpr_ctrl #(
    .COLS_A(COLS_A), .COLS_B(COLS_B),
    .LAST_PAGE_A(LAST_PAGE_A), .LAST_PAGE_B(LAST_PAGE_B),
    .ICON_PAGE(ICON_PAGE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .geoMode(geoMode),
    .hostSetPage(hostSetPage), .hostSetCol(hostSetCol),
    .hostWr(hostWr), .hostRd(hostRd), .hostData(hostData),
    .memCmd(memCmd), .curPage(curPage), .curCol(curCol)
  );

  dpr_store #(
    .MAX_COLS(MAX_COLS), .ICON_PAGE(ICON_PAGE), .PART_PAGE(LAST_PAGE_B)
  ) u_store (
    .clk(clk), .rstN(rstN), .geoMode(geoMode), .memCmd(memCmd),
    .hostRdData(hostRdData), .dispRe(dispRe), .dispPage(dispPage),
    .dispCol(dispCol), .dispData(dispData)
  );

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int COLS_A      = 132,
  parameter int COLS_B      = 160,
  parameter int LAST_PAGE_A = 15,
  parameter int LAST_PAGE_B = 12,
  parameter int ICON_PAGE   = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       geoMode,
  input logic       hostSetPage,
  input logic       hostSetCol,
  input logic       hostWr,
  input logic       hostRd,
  input logic [7:0] hostRdData,
  input logic [4:0] curPage,
  input logic [7:0] curCol
);

  localparam logic [7:0] LC_A = 8'(COLS_A - 1);
  localparam logic [7:0] LC_B = 8'(COLS_B - 1);
  localparam logic [4:0] LP_A = 5'(LAST_PAGE_A);
  localparam logic [4:0] LP_B = 5'(LAST_PAGE_B);
  localparam logic [4:0] IP   = 5'(ICON_PAGE);

  logic       prevMode;
  logic       chg;
  logic       acc;
  logic [7:0] lastNow;
  logic [7:0] lastPrev;
  logic [4:0] pageLimPrev;

  always_ff @(posedge clk) begin
    if (!rstN) prevMode <= 1'b0;
    else       prevMode <= geoMode;
  end

  always_comb begin
    chg         = (geoMode != prevMode);
    acc         = !chg && !hostSetPage && !hostSetCol && (hostWr || hostRd);
    lastNow     = geoMode  ? LC_B : LC_A;
    lastPrev    = prevMode ? LC_B : LC_A;
    pageLimPrev = prevMode ? LP_B : LP_A;
  end

  AST_PAGE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (curPage <= pageLimPrev) || (curPage == IP));                            // R4
  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    curCol <= lastPrev);                                                     // R5
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (acc && curCol < lastNow) |=> (curCol == $past(curCol) + 8'd1));         // R6
  AST_COL_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (acc && curCol == lastNow) |=> $stable(curCol));                         // R6
  AST_ICON_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !hostWr && curPage == IP) |=> (hostRdData[7:1] == 7'd0));        // R3
  AST_MODE_HOME: assert property (@(posedge clk) disable iff (!rstN)
    chg |=> (curPage == 5'd0 && curCol == 8'd0));                            // R11

endmodule

bind disp_page_ram dpr_checker #(
  .COLS_A(COLS_A), .COLS_B(COLS_B),
  .LAST_PAGE_A(LAST_PAGE_A), .LAST_PAGE_B(LAST_PAGE_B),
  .ICON_PAGE(ICON_PAGE)
) u_dprChecker (
  .clk(clk), .rstN(rstN), .geoMode(geoMode),
  .hostSetPage(hostSetPage), .hostSetCol(hostSetCol),
  .hostWr(hostWr), .hostRd(hostRd), .hostRdData(hostRdData),
  .curPage(curPage), .curCol(curCol)
);

// File: tb/test_disp_page_ram.sv
module test_disp_page_ram;

  localparam int NCOL = 160;
  localparam int NPG  = 17;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       geoMode = 1'b0;
  logic       hostSetPage = 1'b0, hostSetCol = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostData = '0;
  logic [7:0] hostRdData;
  logic       dispRe = 1'b0;
  logic [4:0] dispPage = '0;
  logic [7:0] dispCol = '0;
  logic [7:0] dispData;

  int checks = 0, errors = 0;
  bit done = 0;
  string curReq = "R12";

  // Reference model state
  int mdl [NPG*NCOL];
  int mPage = 0, mCol = 0, expHost = 0, expDisp = 0;
  bit mPrevMode = 0;

  always #10 clk = ~clk;

  disp_page_ram i_disp_page_ram (
    .clk(clk), .rstN(rstN), .geoMode(geoMode),
    .hostSetPage(hostSetPage), .hostSetCol(hostSetCol),
    .hostWr(hostWr), .hostRd(hostRd), .hostData(hostData),
    .hostRdData(hostRdData), .dispRe(dispRe), .dispPage(dispPage),
    .dispCol(dispCol), .dispData(dispData)
  );

  function automatic int keepBits(int page, bit mode);
    if (page == 16) return 'h01;
    if (mode && page == 12) return 'h0F;
    return 'hFF;
  endfunction

  function automatic int lastColOf(bit mode);
    return mode ? 159 : 131;
  endfunction

  function automatic bit pageValid(int v, bit mode);
    if (v == 16) return 1;
    return mode ? (v <= 12) : (v <= 15);
  endfunction

  // Next state after the coming clock edge, from the current inputs
  task automatic modelStep();
    int d = int'(dispPage), c = int'(dispCol), hv = int'(hostData);
    if (dispRe) begin
      if (d > 16 || c >= NCOL) expDisp = 0;
      else if (mdl[d*NCOL+c] < 0) expDisp = -1;
      else expDisp = mdl[d*NCOL+c] & keepBits(d, geoMode);
    end
    if (geoMode != mPrevMode) begin
      mPage = 0; mCol = 0;
    end else if (hostSetPage) begin
      if (pageValid(hv, geoMode)) mPage = hv;
    end else if (hostSetCol) begin
      if (hv <= lastColOf(geoMode)) mCol = hv;
    end else if (hostWr || hostRd) begin
      if (hostWr) mdl[mPage*NCOL+mCol] = hv & keepBits(mPage, geoMode);
      else if (mdl[mPage*NCOL+mCol] < 0) expHost = -1;
      else expHost = mdl[mPage*NCOL+mCol] & keepBits(mPage, geoMode);
      if (mCol < lastColOf(geoMode)) mCol = mCol + 1;
    end
    mPrevMode = geoMode;
  endtask

  task automatic compareOuts();
    if (expHost >= 0) begin
      checks++;
      if (int'(hostRdData) != expHost) begin
        errors++;
        $display("FAIL %s hostRdData got %02h expected %02h", curReq, hostRdData, expHost);
      end
    end
    if (expDisp >= 0) begin
      checks++;
      if (int'(dispData) != expDisp) begin
        errors++;
        $display("FAIL %s dispData got %02h expected %02h", curReq, dispData, expDisp);
      end
    end
  endtask

  task automatic drive(input bit sp, input bit sc, input bit wr, input bit rd,
                       input logic [7:0] d, input bit dre,
                       input logic [4:0] dp, input logic [7:0] dc);
    hostSetPage = sp; hostSetCol = sc; hostWr = wr; hostRd = rd; hostData = d;
    dispRe = dre; dispPage = dp; dispCol = dc;
    modelStep();
    @(negedge clk);
    compareOuts();
    hostSetPage = 0; hostSetCol = 0; hostWr = 0; hostRd = 0; dispRe = 0;
  endtask

  task automatic setPg(input logic [7:0] v); drive(1,0,0,0,v,0,'0,'0); endtask
  task automatic setCl(input logic [7:0] v); drive(0,1,0,0,v,0,'0,'0); endtask
  task automatic wrB(input logic [7:0] v);   drive(0,0,1,0,v,0,'0,'0); endtask
  task automatic rdB();                      drive(0,0,0,1,'0,0,'0,'0); endtask
  task automatic dRd(input logic [4:0] p, input logic [7:0] c);
    drive(0,0,0,0,'0,1,p,c);
    drive(0,0,0,0,'0,0,'0,'0);
  endtask

  initial begin
    for (int i = 0; i < NPG*NCOL; i++) mdl[i] = -1;
    repeat (3) @(negedge clk);
    curReq = "R12";
    compareOuts();
    rstN = 1'b1;
    drive(0,0,0,0,'0,0,'0,'0);

    // Mode 0 full pages and column stepping
    curReq = "R1";
    setPg(8'd3); setCl(8'd10); wrB(8'hAA); wrB(8'h55);
    dRd(5'd3, 8'd10); dRd(5'd3, 8'd11);
    setPg(8'd15); setCl(8'd0); wrB(8'hFF); dRd(5'd15, 8'd0);
    curReq = "R7";
    setPg(8'd3); setCl(8'd10); rdB(); rdB(); drive(0,0,0,0,'0,0,'0,'0);

    curReq = "R6";
    setCl(8'd131); wrB(8'h11); wrB(8'h22); dRd(5'd3, 8'd131);
    setCl(8'd130); rdB(); rdB(); rdB();
    curReq = "R5";
    setCl(8'd5); setCl(8'd140); wrB(8'h77); dRd(5'd3, 8'd5);

    curReq = "R3";
    setPg(8'd16); setCl(8'd2); wrB(8'hFF); wrB(8'hFE); dRd(5'd16, 8'd2); dRd(5'd16, 8'd3);
    setCl(8'd2); rdB();

    curReq = "R4";
    setPg(8'd2); setPg(8'd20); setPg(8'd17); setCl(8'd0); wrB(8'h9C); dRd(5'd2, 8'd0);

    curReq = "R9";
    setCl(8'd1); wrB(8'h11);
    setCl(8'd1); drive(0,0,1,0,8'h22,1,5'd2,8'd1); dRd(5'd2, 8'd1);

    curReq = "R10";
    setPg(8'd5); setCl(8'd4); wrB(8'h3C);
    setPg(8'd2); setCl(8'd4); wrB(8'hA5);
    setCl(8'd4); drive(1,1,1,0,8'h05,0,'0,'0); wrB(8'h66);
    drive(0,1,1,1,8'h07,0,'0,'0); wrB(8'h99);
    drive(1,0,1,1,8'd25,0,'0,'0); wrB(8'h44);
    dRd(5'd2, 8'd4); dRd(5'd5, 8'd4); dRd(5'd5, 8'd7); dRd(5'd5, 8'd8);

    curReq = "R11";
    geoMode = 1'b1;
    drive(0,0,1,0,8'hEE,0,'0,'0);
    wrB(8'h44); dRd(5'd0, 8'd0); dRd(5'd0, 8'd1);

    curReq = "R2";
    setPg(8'd13); setCl(8'd150); wrB(8'hC3); dRd(5'd0, 8'd150);
    setPg(8'd12); setCl(8'd159); wrB(8'hFF); wrB(8'h5A); dRd(5'd12, 8'd159);
    setCl(8'd160); setCl(8'd158); rdB(); rdB();
    setPg(8'd11); setCl(8'd145); wrB(8'hB7); dRd(5'd11, 8'd145);
    curReq = "R3";
    setPg(8'd16); setCl(8'd9); wrB(8'hFE); wrB(8'h03); dRd(5'd16, 8'd9); dRd(5'd16, 8'd10);

    curReq = "R8";
    setPg(8'd0); setCl(8'd20);
    for (int k = 0; k < 40; k++) begin
      drive(0,0,1,0,8'(k*37+11),1,5'd0,8'(20 + (k*7)%20));
    end
    dRd(5'd0, 8'd59); dRd(5'd17, 8'd3);

    curReq = "R11";
    geoMode = 1'b0;
    drive(0,0,0,1,'0,0,'0,'0);
    wrB(8'h6E); setCl(8'd0); rdB(); drive(0,0,0,0,'0,0,'0,'0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired in %s", curReq);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule